// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware and software events for a processor core. It holds a set of 32-bit event counters and one cycle counter. The number of event counters is a build parameter. Software reaches every register through a simple word-addressed register bus. Each event counter is programmed with an event number and two privilege filters. It then counts pulses from a small vector of hardware event lines. If the event number is the software code, it counts writes to the software increment register instead.

Every per-counter bit vector uses the same bit layout. Event counter `i` owns bit `i`, and the cycle counter owns bit 31. The counter enable, interrupt enable and overflow status vectors are each reached through a set address and a clear address. A counter that wraps to zero sets its overflow bit. The single interrupt line is high while an enabled, interrupt-enabled, implemented counter has its overflow bit set and counting is globally on.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all counters, enables and overflow bits are zero and `ovf_irq` is low. The control word at byte address 0x000 reads `NUM_CNT` in bits 15:11, the long-cycle flag in bit 6 and the global enable in bit 0.
- R2: Only implemented bits can be stored in the per-counter vectors. These are bits `NUM_CNT-1..0` and bit 31, and any other bit reads zero.
- R3: A hardware event advances counter `i` on a clock edge only when three things hold: the global enable (control bit 0) is 1, its counter enable bit is 1, and its event number (type bits 9:0, value `k` from 1 to `EVT_W`) selects a line `hw_evt[k-1]` that is high. The cycle counter advances every clock under the global enable and counter enable bit 31.
- R4: Type bit 31 blocks hardware counting while `priv_lvl` is 0. Type bit 30 blocks it while `priv_lvl` is 1. Levels 2 and 3 are never filtered.
- R5: A write to the software increment register (0x01C) adds one to each counter `i` below 31 whose written bit is 1, whose event number is 0 and whose counter enable bit is 1. The global enable is not needed. Bit 31 and bits of other counters have no effect.
- R6: Event counters are 32 bits wide. An increment from 0xFFFFFFFF gives 0 and sets that counter's overflow bit.
- R7: A write to the overflow set address (0x014) ORs the data into the overflow status, so a write of zero changes nothing. A write to the overflow clear address (0x018) clears the bits written as 1.
- R8: `ovf_irq` is 1 exactly when the global enable is 1 and the AND of overflow, counter enable, interrupt enable and the implemented-bit mask is non-zero.
- R9: A control write with bit 1 set clears all event counters. A control write with bit 2 set clears the cycle counter. Neither bit is stored.
- R10: With control bit 6 at 0 the cycle counter counts only its low word, which wraps at 32 bits and raises overflow bit 31, while its high word holds. With bit 6 at 1 it counts all 64 bits.
- R11: Counter enable (set 0x004, clear 0x008) and interrupt enable (set 0x00C, clear 0x010) use write-one-to-set and write-one-to-clear. Both addresses of a pair read the current vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 9 | Byte address; event counters at 0x100+4i, event types at 0x180+4i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | EVT_W | Hardware event pulses, one cycle each |
| priv_lvl | input | 2 | Current privilege level, 0 = user, 1 = kernel |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
Every register write and every event pulse takes effect at the clock edge where it is presented. Its result appears on `bus_rdata` for that address from then on, because reads are combinational. `ovf_irq` is a function of registers only, so it changes together with the overflow and enable state on that same edge. The bench drives stimulus on the falling edge and steps a behavioural model on the rising edge. It compares `ovf_irq` on every falling edge and register reads one time step after the address is set. No check depends on the order of processes at the active edge.

// File: rtl/pmu_pkg.sv
// Package: address map, control and type field positions, and the
// implemented-bit mask shared by the performance monitor unit.
package pmu_pkg;
    localparam int CYC_IDX = 31;

    localparam logic [8:0] A_CTRL    = 9'h000;
    localparam logic [8:0] A_CEN_SET = 9'h004;
    localparam logic [8:0] A_CEN_CLR = 9'h008;
    localparam logic [8:0] A_IEN_SET = 9'h00C;
    localparam logic [8:0] A_IEN_CLR = 9'h010;
    localparam logic [8:0] A_OVF_SET = 9'h014;
    localparam logic [8:0] A_OVF_CLR = 9'h018;
    localparam logic [8:0] A_SWINC   = 9'h01C;
    localparam logic [8:0] A_CYC_LO  = 9'h020;
    localparam logic [8:0] A_CYC_HI  = 9'h024;
    localparam logic [1:0] BANK_CNT  = 2'b10;
    localparam logic [1:0] BANK_TYP  = 2'b11;

    localparam int CTL_E  = 0;
    localparam int CTL_P  = 1;
    localparam int CTL_C  = 2;
    localparam int CTL_LC = 6;

    localparam int EVNUM_W = 10;
    localparam int TYP_XU  = 31;
    localparam int TYP_XK  = 30;
    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_KERN = 2'd1;

    // Implemented counters: bits n-1..0 plus the cycle counter bit.
    function automatic logic [31:0] valid_mask(input int n);
        logic [31:0] m;
        m = '0;
        m[CYC_IDX] = 1'b1;
        for (int i = 0; i < CYC_IDX; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pmu_bitvec.sv
// Per-counter bit vector with write-one-to-set / write-one-to-clear ports
// plus a hardware set input. Assumes set and clear never share a cycle.
// Only bits in KEEP can ever be 1.
module pmu_bitvec #(
    parameter logic [31:0] KEEP = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);
    logic [31:0] set_bits, clr_bits;

    // Select the write data for the set or clear action.
    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Update the vector; hardware set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_bits) | set_bits | hw_set) & KEEP;
    end
endmodule

// File: rtl/pmu_evcnt.sv
// One 32-bit event counter with its event type register. Counts a selected
// hardware line (filtered by privilege, gated by global and counter enable)
// or a software increment pulse. Priority: clear-all, value write, increment.
module pmu_evcnt
    import pmu_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             cnt_en,
    input  logic             typ_we,
    input  logic             val_we,
    input  logic             clr_all,
    input  logic             sw_pulse,
    input  logic [31:0]      wdata,
    input  logic [EVT_W-1:0] hw_evt,
    input  logic [1:0]       priv,
    output logic [31:0]      count,
    output logic [31:0]      evtype,
    output logic             wrap
);
    logic [EVNUM_W-1:0] evnum;
    logic               excl_user, excl_kern;
    logic               line_hit, filtered, inc;

    // Pick the hardware line named by the event number.
    always_comb begin
        line_hit = 1'b0;
        for (int k = 0; k < EVT_W; k++)
            if (evnum == EVNUM_W'(k + 1) && hw_evt[k]) line_hit = 1'b1;
    end

    // Decide whether this cycle adds one to the counter.
    always_comb begin
        filtered = (priv == PRIV_USER && excl_user) || (priv == PRIV_KERN && excl_kern);
        inc      = (glob_en && cnt_en && line_hit && !filtered)
                 || (sw_pulse && cnt_en && evnum == '0);
        wrap     = inc && !clr_all && !val_we && (&count);
        evtype   = {excl_user, excl_kern, 20'b0, evnum};
    end

    // Hold the count value.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (clr_all) count <= '0;
        else if (val_we)  count <= wdata;
        else if (inc)     count <= count + 32'd1;
    end

    // Hold the event type fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evnum     <= '0;
            excl_user <= 1'b0;
            excl_kern <= 1'b0;
        end else if (typ_we) begin
            evnum     <= wdata[EVNUM_W-1:0];
            excl_user <= wdata[TYP_XU];
            excl_kern <= wdata[TYP_XK];
        end
    end
endmodule

// File: rtl/pmu_cyccnt.sv
// Cycle counter, 64 bits of storage. In short mode only the low word counts
// and wraps; in long mode all 64 bits count. Clear beats writes beats count.
module pmu_cyccnt (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        long_mode,
    input  logic        clr,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [31:0] wdata,
    output logic [63:0] cyc,
    output logic        wrap
);
    logic [63:0] nxt;

    // Next value and wrap flag.
    always_comb begin
        nxt  = cyc;
        wrap = 1'b0;
        if (clr) begin
            nxt = '0;
        end else if (lo_we) begin
            nxt[31:0] = wdata;
        end else if (hi_we) begin
            nxt[63:32] = wdata;
        end else if (run) begin
            if (long_mode) begin
                wrap = &cyc;
                nxt  = cyc + 64'd1;
            end else begin
                wrap      = &cyc[31:0];
                nxt[31:0] = cyc[31:0] + 32'd1;
            end
        end
    end

    // Register the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= nxt;
    end
endmodule

// File: rtl/perf_mon_unit.sv
// Performance monitor top: register decode, control word, per-counter bit
// vectors, event counters, cycle counter and interrupt. Assumes one bus
// write per cycle and NUM_CNT between 0 and 31.
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 6,
    parameter int EVT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [8:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [EVT_W-1:0] hw_evt,
    input  logic [1:0]       priv_lvl,
    output logic             ovf_irq
);
    localparam logic [31:0] VALID   = valid_mask(NUM_CNT);
    localparam logic [4:0]  N_FIELD = 5'(NUM_CNT);

    logic        in_cnt_bank, in_typ_bank;
    logic [4:0]  widx;
    logic        wr_ctrl, wr_swinc, p_pulse, c_pulse;
    logic        glob_en, lc_mode;
    logic [31:0] cen_q, ien_q, ovf_q, wrap_vec, sw_vec, ctrl_rd;
    logic [31:0] cnt_arr [32];
    logic [31:0] typ_arr [32];
    logic [63:0] cyc;
    logic        cyc_wrap;

    // Address decode for banks and single registers.
    always_comb begin
        in_cnt_bank = bus_addr[8:7] == BANK_CNT && bus_addr[1:0] == 2'b00;
        in_typ_bank = bus_addr[8:7] == BANK_TYP && bus_addr[1:0] == 2'b00;
        widx        = bus_addr[6:2];
        wr_ctrl     = bus_we && bus_addr == A_CTRL;
        wr_swinc    = bus_we && bus_addr == A_SWINC;
        p_pulse     = wr_ctrl && bus_wdata[CTL_P];
        c_pulse     = wr_ctrl && bus_wdata[CTL_C];
        sw_vec      = wr_swinc ? bus_wdata : '0;
        ctrl_rd     = {16'b0, N_FIELD, 4'b0, lc_mode, 5'b0, glob_en};
    end

    // Stored control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            lc_mode <= 1'b0;
        end else if (wr_ctrl) begin
            glob_en <= bus_wdata[CTL_E];
            lc_mode <= bus_wdata[CTL_LC];
        end
    end

    pmu_bitvec #(.KEEP(VALID)) u_cen (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_we && bus_addr == A_CEN_SET), .clr_we(bus_we && bus_addr == A_CEN_CLR),
        .wdata(bus_wdata), .hw_set(32'b0), .q(cen_q));

    pmu_bitvec #(.KEEP(VALID)) u_ien (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_we && bus_addr == A_IEN_SET), .clr_we(bus_we && bus_addr == A_IEN_CLR),
        .wdata(bus_wdata), .hw_set(32'b0), .q(ien_q));

    pmu_bitvec #(.KEEP(VALID)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_we && bus_addr == A_OVF_SET), .clr_we(bus_we && bus_addr == A_OVF_CLR),
        .wdata(bus_wdata), .hw_set(wrap_vec), .q(ovf_q));

    pmu_cyccnt u_cyc (
        .clk(clk), .rst_n(rst_n),
        .run(glob_en && cen_q[CYC_IDX]), .long_mode(lc_mode), .clr(c_pulse),
        .lo_we(bus_we && bus_addr == A_CYC_LO), .hi_we(bus_we && bus_addr == A_CYC_HI),
        .wdata(bus_wdata), .cyc(cyc), .wrap(cyc_wrap));

    for (genvar gi = 0; gi < 32; gi++) begin : g_slot
        if (gi < NUM_CNT) begin : g_ev
            pmu_evcnt #(.EVT_W(EVT_W)) u_ev (
                .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_en(cen_q[gi]),
                .typ_we(bus_we && in_typ_bank && widx == 5'(gi)),
                .val_we(bus_we && in_cnt_bank && widx == 5'(gi)),
                .clr_all(p_pulse), .sw_pulse(sw_vec[gi]), .wdata(bus_wdata),
                .hw_evt(hw_evt), .priv(priv_lvl),
                .count(cnt_arr[gi]), .evtype(typ_arr[gi]), .wrap(wrap_vec[gi]));
        end else begin : g_none
            assign cnt_arr[gi] = '0;
            assign typ_arr[gi] = '0;
            if (gi == CYC_IDX) begin : g_cyc
                assign wrap_vec[gi] = cyc_wrap;
            end else begin : g_pad
                assign wrap_vec[gi] = 1'b0;
            end
        end
    end

    // Level interrupt from masked overflow state.
    assign ovf_irq = glob_en && |(ovf_q & cen_q & ien_q & VALID);

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (in_cnt_bank)      bus_rdata = cnt_arr[widx];
        else if (in_typ_bank) bus_rdata = typ_arr[widx];
        else begin
            case (bus_addr)
                A_CTRL:               bus_rdata = ctrl_rd;
                A_CEN_SET, A_CEN_CLR: bus_rdata = cen_q;
                A_IEN_SET, A_IEN_CLR: bus_rdata = ien_q;
                A_OVF_SET, A_OVF_CLR: bus_rdata = ovf_q;
                A_CYC_LO:             bus_rdata = cyc[31:0];
                A_CYC_HI:             bus_rdata = cyc[63:32];
                default:              bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmu_checker.sv
// Checker for perf_mon_unit: temporal properties on ports and internal state.
module pmu_checker
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [8:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        glob_en,
    input logic        lc_mode,
    input logic [31:0] cen_q,
    input logic [31:0] ovf_q,
    input logic [31:0] cnt0,
    input logic [63:0] cyc,
    input logic        ovf_irq
);
    localparam logic [31:0] VALID = valid_mask(NUM_CNT);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !ovf_irq);

    p_en_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_q & ~VALID) == 32'b0);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_OVF_CLR) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    p_p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL && bus_wdata[CTL_P]) |=> cnt0 == 32'b0);

    p_short_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lc_mode && !(bus_we && (bus_addr == A_CYC_HI || bus_addr == A_CTRL))) |=> $stable(cyc[63:32]));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !bus_we) |=> $stable(cnt0));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_CNT(NUM_CNT)) u_pmu_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .glob_en(glob_en), .lc_mode(lc_mode),
    .cen_q(cen_q), .ovf_q(ovf_q), .cnt0(cnt_arr[0]), .cyc(cyc), .ovf_irq(ovf_irq));

// File: tb/perf_mon_unit_test.sv
// Bench: behavioural reference model stepped on every rising edge,
// interrupt compared on every falling edge, register reads compared on demand.
module perf_mon_unit_test;
    localparam int N  = 6;
    localparam int EW = 4;
    localparam logic [31:0] VM = 32'h8000_003F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [EW-1:0] hw = '0;
    logic [1:0]    priv = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_cnt [N];
    logic [31:0] m_typ [N];
    logic [63:0] m_cyc;
    logic [31:0] m_cen, m_ien, m_ovf;
    bit          m_e, m_lc;

    always #4 clk = ~clk;

    perf_mon_unit #(.NUM_CNT(N), .EVT_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .hw_evt(hw), .priv_lvl(priv), .ovf_irq(irq));

    // Reference model step.
    always @(posedge clk) begin : mdl
        logic [31:0] wrapv;
        int ev;
        bit inc, filt;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
            m_cyc = 0; m_cen = 0; m_ien = 0; m_ovf = 0; m_e = 0; m_lc = 0;
        end else begin
            wrapv = 0;
            for (int i = 0; i < N; i++) begin
                ev   = int'(m_typ[i][9:0]);
                filt = (priv == 0 && m_typ[i][31]) || (priv == 1 && m_typ[i][30]);
                inc  = 0;
                if (m_e && m_cen[i] && ev >= 1 && ev <= EW && !filt)
                    if (hw[ev-1]) inc = 1;
                if (we && addr == 9'h01C && wdata[i] && m_cen[i] && ev == 0) inc = 1;
                if (we && addr == 9'h000 && wdata[1]) m_cnt[i] = 0;
                else if (we && addr == 9'(256 + 4*i)) m_cnt[i] = wdata;
                else if (inc) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) wrapv[i] = 1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
                if (we && addr == 9'(384 + 4*i)) m_typ[i] = wdata & 32'hC000_03FF;
            end
            if (we && addr == 9'h000 && wdata[2]) m_cyc = 0;
            else if (we && addr == 9'h020) m_cyc[31:0] = wdata;
            else if (we && addr == 9'h024) m_cyc[63:32] = wdata;
            else if (m_e && m_cen[31]) begin
                if (m_lc) begin
                    if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wrapv[31] = 1;
                    m_cyc = m_cyc + 1;
                end else begin
                    if (m_cyc[31:0] == 32'hFFFF_FFFF) wrapv[31] = 1;
                    m_cyc[31:0] = m_cyc[31:0] + 1;
                end
            end
            if (we && addr == 9'h004) m_cen = (m_cen | wdata) & VM;
            if (we && addr == 9'h008) m_cen = m_cen & ~wdata;
            if (we && addr == 9'h00C) m_ien = (m_ien | wdata) & VM;
            if (we && addr == 9'h010) m_ien = m_ien & ~wdata;
            if (we && addr == 9'h018) m_ovf = m_ovf & ~wdata;
            if (we && addr == 9'h014) m_ovf = m_ovf | wdata;
            m_ovf = (m_ovf | wrapv) & VM;
            if (we && addr == 9'h000) begin m_e = wdata[0]; m_lc = wdata[6]; end
        end
    end

    function automatic logic [31:0] model_read(input logic [8:0] a);
        if (a[8:7] == 2'b10 && a[1:0] == 0) return (int'(a[6:2]) < N) ? m_cnt[a[6:2]] : 32'h0;
        if (a[8:7] == 2'b11 && a[1:0] == 0) return (int'(a[6:2]) < N) ? m_typ[a[6:2]] : 32'h0;
        case (a)
            9'h000: return (32'(N) << 11) | (32'(m_lc) << 6) | 32'(m_e);
            9'h004, 9'h008: return m_cen;
            9'h00C, 9'h010: return m_ien;
            9'h014, 9'h018: return m_ovf;
            9'h020: return m_cyc[31:0];
            9'h024: return m_cyc[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Interrupt compared against the model on every falling edge (R8).
    always @(negedge clk) begin
        if (rst_n && !done) chk("R8 irq", 64'(irq), 64'(m_e && ((m_ovf & m_cen & m_ien & VM) != 0)));
    end

    task automatic rd(input logic [8:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        we = 0; addr = a;
        #1;
        v = rdata;
        chk(tag, 64'(rdata), 64'(model_read(a)));
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd_all(input string tag);
        logic [31:0] v;
        for (int a = 0; a <= 9'h024; a += 4) rd(9'(a), tag, v);
        for (int i = 0; i < N; i++) begin
            rd(9'(256 + 4*i), tag, v);
            rd(9'(384 + 4*i), tag, v);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(9'h000, "R1 ctrl", v);  chk("R1 ctrl literal", 64'(v), 64'h3000);
        chk("R1 irq low", 64'(irq), 64'h0);
        rd_all("R1 regs");
        // R2 / R11 set-clear pairs and implemented mask
        wr(9'h004, 32'hFFFF_FFFF);
        rd(9'h004, "R2 cen", v);      chk("R2 cen mask", 64'(v), 64'h8000_003F);
        rd(9'h008, "R11 cen pair", v); chk("R11 pair read", 64'(v), 64'h8000_003F);
        wr(9'h008, 32'h0000_0008);
        rd(9'h004, "R11 clr", v);     chk("R11 w1c", 64'(v), 64'h8000_0037);
        wr(9'h004, 32'h0000_0008);
        wr(9'h00C, 32'h0000_0100);
        rd(9'h010, "R11 ien", v);     chk("R2 ien unimpl", 64'(v), 64'h0);
        // event types
        wr(9'h180, 32'h0000_0001);
        wr(9'h184, 32'h8000_0002);
        wr(9'h188, 32'h0000_0000);
        wr(9'h18C, 32'h4000_0001);
        wr(9'h190, 32'h0000_0003);
        rd(9'h184, "R4 type", v);     chk("R4 type read", 64'(v), 64'h8000_0002);
        // R3: no counting with global enable off
        hw = 4'hF;
        repeat (5) @(negedge clk);
        hw = 0;
        rd(9'h100, "R3 off", v);      chk("R3 off literal", 64'(v), 64'h0);
        // R3 / R4: counting with privilege patterns
        wr(9'h000, 32'h1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            hw = 4'(i * 7);
            priv = 2'(i % 4);
        end
        @(negedge clk);
        hw = 0;
        rd_all("R3 R4 counting");
        // R5 / R6: software increment wrap with global enable off
        wr(9'h000, 32'h0);
        wr(9'h108, 32'hFFFF_FFFF);
        wr(9'h018, 32'hFFFF_FFFF);
        wr(9'h01C, 32'h8000_0006);
        rd(9'h108, "R5 swinc wrap", v); chk("R6 wrap literal", 64'(v), 64'h0);
        rd(9'h104, "R5 other type", v);
        rd(9'h014, "R6 ovf", v);        chk("R6 ovf bit2", 64'(v), 64'h4);
        wr(9'h01C, 32'h0000_0004);
        rd(9'h108, "R5 swinc one", v);  chk("R5 literal", 64'(v), 64'h1);
        // R8 interrupt gating
        wr(9'h00C, 32'h0000_0004);
        chk("R8 off", 64'(irq), 64'h0);
        wr(9'h000, 32'h1);
        chk("R8 on", 64'(irq), 64'h1);
        wr(9'h008, 32'h4);
        chk("R8 cen clr", 64'(irq), 64'h0);
        wr(9'h004, 32'h4);
        chk("R8 cen set", 64'(irq), 64'h1);
        wr(9'h018, 32'h4);
        chk("R8 ovf clr", 64'(irq), 64'h0);
        // R7 overflow set
        wr(9'h014, 32'h0);
        rd(9'h014, "R7 zero write", v); chk("R7 zero literal", 64'(v), 64'h0);
        wr(9'h014, 32'h30);
        rd(9'h014, "R7 or", v);         chk("R7 or literal", 64'(v), 64'h30);
        wr(9'h014, 32'hFFFF_FFFF);
        rd(9'h018, "R7 mask", v);       chk("R7 mask literal", 64'(v), 64'h8000_003F);
        wr(9'h018, 32'hFFFF_FFFF);
        // R6: hardware wrap
        wr(9'h100, 32'hFFFF_FFFF);
        @(negedge clk); hw = 4'h1; priv = 2;
        @(negedge clk); hw = 0;
        rd(9'h100, "R6 hw wrap", v);    chk("R6 hw literal", 64'(v), 64'h0);
        rd(9'h014, "R6 hw ovf", v);
        // R9 clears
        wr(9'h000, 32'h3);
        rd(9'h108, "R9 P", v);          chk("R9 P literal", 64'(v), 64'h0);
        rd(9'h000, "R9 not stored", v); chk("R9 ctrl literal", 64'(v), 64'h3001);
        wr(9'h000, 32'h5);
        rd(9'h024, "R9 C", v);          chk("R9 C literal", 64'(v), 64'h0);
        rd_all("R9 regs");
        // R10 short and long cycle counting
        wr(9'h000, 32'h0);
        wr(9'h020, 32'hFFFF_FFFE);
        wr(9'h024, 32'h5);
        wr(9'h018, 32'hFFFF_FFFF);
        wr(9'h000, 32'h1);
        repeat (3) @(negedge clk);
        wr(9'h000, 32'h0);
        rd(9'h024, "R10 short hi", v);  chk("R10 hold literal", 64'(v), 64'h5);
        rd(9'h014, "R10 short ovf", v); chk("R10 ovf31", 64'(v[31]), 64'h1);
        rd(9'h020, "R10 short lo", v);
        wr(9'h018, 32'hFFFF_FFFF);
        wr(9'h020, 32'hFFFF_FFFE);
        wr(9'h000, 32'h41);
        repeat (3) @(negedge clk);
        wr(9'h000, 32'h40);
        rd(9'h024, "R10 long hi", v);   chk("R10 carry literal", 64'(v), 64'h6);
        rd(9'h014, "R10 long ovf", v);  chk("R10 no ovf", 64'(v), 64'h0);
        rd_all("R10 regs");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule